// File: doc/BRIEF.md
# Four-Word Table Mixing Datapath

This block is the unkeyed whitening stage of a 128-bit block cipher. It holds four 32-bit words and mixes them over several clock cycles, one step per cycle, using byte-indexed lookups into two 256-entry tables of 32-bit words. A single datapath serves both directions. A direction input sets the order of the operations through selectors.

In the forward direction the unit first adds four sub-key words to the input block. It then runs eight mixing rounds. In the backward direction it runs eight rounds of a different shape and then subtracts four other sub-key words. Each direction takes nine clock cycles from the accepted start to the result. The tables are filled through a write port before work begins. A table read returns its word in the same cycle, so one round completes in one cycle. The block is used by writing both tables, presenting a block, two key sets and a direction, and pulsing start. The result is taken when done pulses.

Top module: `mix_unit`

## Requirements
- R1: During and right after a synchronous reset (rst_n low at a clock edge), done is 0 and data_out is all zeros.
- R2: Word k of a block sits at bits [32k+31:32k]. In the forward direction (dir_bwd = 0), the first step sets every word k to data_in word k plus key_add word k, modulo 2^32.
- R3: Byte j of a word is bits [8j+7:8j], so byte 0 is the least significant byte. Tables are named T0 and T1. A forward round with W0 as the index word does three things: W1 becomes (W1 XOR T0[byte0]) + T1[byte1], W2 becomes W2 + T0[byte2], and W3 becomes W3 XOR T1[byte3].
- R4: In forward rounds 0 and 4, W0 then gains the new W3. In rounds 1 and 5, W0 gains the new W1. In rounds 2, 3, 6 and 7, W0 is unchanged. The words then move down one place, so the new (W0, W1, W2, W3) is (W1, W2, W3, W0).
- R5: A backward round (dir_bwd = 1) first reduces W0: by W3 in rounds 2 and 6, by W1 in rounds 3 and 7, and not at all in other rounds. The reduced W0 is then the index word. W1 becomes W1 XOR T1[byte0], W2 becomes W2 - T0[byte3], and W3 becomes (W3 - T1[byte2]) XOR T0[byte1].
- R6: At the end of each backward round the new (W0, W1, W2, W3) is (W1, W2, W3, reduced W0 rotated left by 24 bits).
- R7: After the eighth backward round, every word k has key_sub word k subtracted from it, modulo 2^32.
- R8: If start is sampled high at a clock edge while the unit is idle, done is high for exactly one cycle following the ninth edge counted from that edge. data_out carries the result while done is high and holds it until the next accepted start.
- R9: While a run is in progress, start is ignored. A changed data_in, dir_bwd or start pulse during the run does not alter the result.
- R10: When tbl_we is high at a clock edge, tbl_wdata is written to entry tbl_addr of T0 (tbl_sel = 0) or T1 (tbl_sel = 1). Later rounds use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| dir_bwd | input | 1 | 0 forward, 1 backward, sampled with start |
| data_in | input | 128 | Input block, word k at bits [32k+31:32k] |
| key_add | input | 128 | Four sub-key words added in forward direction |
| key_sub | input | 128 | Four sub-key words subtracted in backward direction |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | Table select, 0 for T0, 1 for T1 |
| tbl_addr | input | 8 | Table entry index |
| tbl_wdata | input | 32 | Table write data |
| data_out | output | 128 | Result block |
| done | output | 1 | One-cycle pulse when data_out is valid |

## Verification
The result and the done pulse are due in the ninth cycle after the edge that accepts start. The bench sets start between edges, counts eight further falling edges, and requires done to stay low before the eighth of them. At that edge it compares data_out with a model computed from the requirements, and done must have risen. One falling edge later it checks that done has dropped and that data_out holds its value. Table writes are checked by the results of later runs. A start pulse issued in the middle of a run is checked by requiring the first result unchanged on its own schedule.

// File: rtl/mix_pkg.sv
// Shared constants, types and helpers for the four-word mixing datapath.
// Assumes 32-bit words, byte-wide table indices and an eight-round schedule.
package mix_pkg;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 4;
    localparam int BYTE_W   = 8;
    localparam int ROUNDS   = 8;
    localparam int TBL_AW   = BYTE_W;
    localparam int TBL_DEPTH = 1 << TBL_AW;
    localparam int BWD_ROT  = 24;
    localparam int STEP_W   = $clog2(ROUNDS + 1);

    typedef logic [WORD_W-1:0]              word_t;
    typedef logic [NWORDS-1:0][WORD_W-1:0]  blk_t;
    typedef logic [TBL_AW-1:0]              taddr_t;

    // Cyclic left rotation of one word
    function automatic word_t rotl(input word_t v, input int unsigned n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    // Byte j of a word, byte 0 being least significant
    function automatic taddr_t byte_of(input word_t v, input int unsigned j);
        return v[j*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/mix_sbox.sv
// One lookup table: write port synchronous, two read ports combinational.
// Assumes the contents are loaded before use; the array itself has no reset.
module mix_sbox
    import mix_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  taddr_t waddr,
    input  word_t  wdata,
    input  taddr_t raddr_a,
    input  taddr_t raddr_b,
    output word_t  rdata_a,
    output word_t  rdata_b
);
    word_t mem [TBL_DEPTH];

    // Store a loaded entry
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Same-cycle reads on both ports
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R10: a write lands in the addressed entry
    assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mix_round.sv
// Combinational mixing round for either direction. Produces table read
// addresses from the index word and combines the returned words.
// Assumes same-cycle table data; phase is the round number modulo 4.
module mix_round
    import mix_pkg::*;
(
    input  blk_t       src,
    input  logic       bwd,
    input  logic [1:0] phase,
    output taddr_t     t0_ra,
    output taddr_t     t0_rb,
    output taddr_t     t1_ra,
    output taddr_t     t1_rb,
    input  word_t      t0_a,
    input  word_t      t0_b,
    input  word_t      t1_a,
    input  word_t      t1_b,
    output blk_t       res
);
    word_t w0_red;
    word_t idx;
    word_t n0, n1, n2, n3;

    // Backward rounds reduce W0 before it indexes the tables
    always_comb begin
        unique case (phase)
            2'd2:    w0_red = src[0] - src[3];
            2'd3:    w0_red = src[0] - src[1];
            default: w0_red = src[0];
        endcase
        idx = bwd ? w0_red : src[0];
    end

    // Route index bytes to the four read ports per direction
    always_comb begin
        if (bwd) begin
            t0_ra = byte_of(idx, 3);
            t0_rb = byte_of(idx, 1);
            t1_ra = byte_of(idx, 0);
            t1_rb = byte_of(idx, 2);
        end else begin
            t0_ra = byte_of(idx, 0);
            t0_rb = byte_of(idx, 2);
            t1_ra = byte_of(idx, 1);
            t1_rb = byte_of(idx, 3);
        end
    end

    // Combine table words with the data words and rotate positions
    always_comb begin
        if (bwd) begin
            n1 = src[1] ^ t1_a;
            n2 = src[2] - t0_a;
            n3 = (src[3] - t1_b) ^ t0_b;
            n0 = rotl(w0_red, BWD_ROT);
        end else begin
            n1 = (src[1] ^ t0_a) + t1_a;
            n2 = src[2] + t0_b;
            n3 = src[3] ^ t1_b;
            unique case (phase)
                2'd0:    n0 = src[0] + n3;
                2'd1:    n0 = src[0] + n1;
                default: n0 = src[0];
            endcase
        end
        res[0] = n1;
        res[1] = n2;
        res[2] = n3;
        res[3] = n0;
    end
endmodule

// File: rtl/mix_seq.sv
// Step sequencer: accepts start when idle, counts ROUNDS+1 steps and
// pulses done after the last. Assumes start is a level sampled each edge.
module mix_seq
    import mix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(ROUNDS);

    // Start only counts when no run is active
    assign accept = start && !busy;

    // Advance the step count and raise done after the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                step <= STEP_W'(1);
            end else if (busy) begin
                if (step == LAST) begin
                    busy <= 1'b0;
                    step <= '0;
                    done <= 1'b1;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end
        end
    end

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an active run advances by one step per cycle
    assert_step_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step != LAST |=> busy && step == $past(step) + STEP_W'(1));
endmodule

// File: rtl/mix_unit.sv
// Top of the mixing datapath. Step 0 runs on the input block in the start
// cycle; later steps run on the held block. Forward: key add, then rounds.
// Backward: rounds, then key subtraction. Tables are loaded beforehand.
module mix_unit
    import mix_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dir_bwd,
    input  logic [127:0] data_in,
    input  logic [127:0] key_add,
    input  logic [127:0] key_sub,
    input  logic         tbl_we,
    input  logic         tbl_sel,
    input  logic [7:0]   tbl_addr,
    input  logic [31:0]  tbl_wdata,
    output logic [127:0] data_out,
    output logic         done
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(ROUNDS);

    logic              accept, busy;
    logic [STEP_W-1:0] step, cur_step;
    logic              dir_q, cur_bwd;
    logic [1:0]        phase;
    blk_t              d_q, src, rnd_out, nxt;
    blk_t              kadd, ksub;
    taddr_t            ra [2];
    taddr_t            rb [2];
    word_t             rda [2];
    word_t             rdb [2];

    mix_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .step   (step),
        .done   (done)
    );

    // Pick the working block, direction and round phase for this cycle
    always_comb begin
        src      = busy ? d_q : blk_t'(data_in);
        cur_step = busy ? step : '0;
        cur_bwd  = busy ? dir_q : dir_bwd;
        phase    = cur_bwd ? cur_step[1:0] : cur_step[1:0] - 2'd1;
        kadd     = blk_t'(key_add);
        ksub     = blk_t'(key_sub);
    end

    generate
        for (genvar t = 0; t < 2; t++) begin : g_tbl
            mix_sbox u_tbl (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (tbl_we && (tbl_sel == t[0])),
                .waddr   (tbl_addr),
                .wdata   (tbl_wdata),
                .raddr_a (ra[t]),
                .raddr_b (rb[t]),
                .rdata_a (rda[t]),
                .rdata_b (rdb[t])
            );
        end
    endgenerate

    mix_round u_round (
        .src   (src),
        .bwd   (cur_bwd),
        .phase (phase),
        .t0_ra (ra[0]),
        .t0_rb (rb[0]),
        .t1_ra (ra[1]),
        .t1_rb (rb[1]),
        .t0_a  (rda[0]),
        .t0_b  (rdb[0]),
        .t1_a  (rda[1]),
        .t1_b  (rdb[1]),
        .res   (rnd_out)
    );

    // Choose key add, key subtraction or a round for the next block
    always_comb begin
        nxt = rnd_out;
        if (!cur_bwd && cur_step == '0) begin
            for (int k = 0; k < NWORDS; k++) nxt[k] = src[k] + kadd[k];
        end else if (cur_bwd && cur_step == LAST) begin
            for (int k = 0; k < NWORDS; k++) nxt[k] = src[k] - ksub[k];
        end
    end

    // Hold the working block and latch the direction on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q   <= '0;
            dir_q <= 1'b0;
        end else if (accept) begin
            d_q   <= nxt;
            dir_q <= dir_bwd;
        end else if (busy) begin
            d_q   <= nxt;
        end
    end

    assign data_out = d_q;

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && data_out == '0));

    // R8: an idle unit without start keeps its result
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(data_out));

    // R9: start during a run leaves the latched direction alone
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(dir_q));
endmodule

// File: tb/tb_mix_unit.sv
// Self-checking bench: loads random tables, runs directed and random blocks
// in both directions and compares against models built from the requirements.
module tb_mix_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dir_bwd = 1'b0;
    logic [127:0] data_in = '0;
    logic [127:0] key_add = '0;
    logic [127:0] key_sub = '0;
    logic         tbl_we = 1'b0;
    logic         tbl_sel = 1'b0;
    logic [7:0]   tbl_addr = '0;
    logic [31:0]  tbl_wdata = '0;
    logic [127:0] data_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] t0m [256];
    logic [31:0] t1m [256];

    mix_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_bwd(dir_bwd),
        .data_in(data_in), .key_add(key_add), .key_sub(key_sub),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .data_out(data_out), .done(done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog R8: actual %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    // Forward model per R2, R3, R4
    function automatic logic [127:0] fwd_model(input logic [127:0] m, input logic [127:0] k);
        logic [31:0] w [4];
        logic [31:0] a, b, c, e;
        for (int i = 0; i < 4; i++) w[i] = m[32*i +: 32] + k[32*i +: 32];
        for (int r = 0; r < 8; r++) begin
            a = (w[1] ^ t0m[w[0][7:0]]) + t1m[w[0][15:8]];
            b = w[2] + t0m[w[0][23:16]];
            c = w[3] ^ t1m[w[0][31:24]];
            e = w[0];
            if (r % 4 == 0) e = e + c;
            if (r % 4 == 1) e = e + a;
            w[0] = a; w[1] = b; w[2] = c; w[3] = e;
        end
        return {w[3], w[2], w[1], w[0]};
    endfunction

    // Backward model per R5, R6, R7
    function automatic logic [127:0] bwd_model(input logic [127:0] m, input logic [127:0] k);
        logic [31:0] w [4];
        logic [31:0] a, b, c, e;
        for (int i = 0; i < 4; i++) w[i] = m[32*i +: 32];
        for (int r = 0; r < 8; r++) begin
            e = w[0];
            if (r % 4 == 2) e = e - w[3];
            if (r % 4 == 3) e = e - w[1];
            a = w[1] ^ t1m[e[7:0]];
            b = w[2] - t0m[e[31:24]];
            c = (w[3] - t1m[e[23:16]]) ^ t0m[e[15:8]];
            w[0] = a; w[1] = b; w[2] = c; w[3] = rl(e, 24);
        end
        for (int i = 0; i < 4; i++) w[i] = w[i] - k[32*i +: 32];
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tbl_write(input logic sel, input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_addr = a; tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        if (sel) t1m[a] = v; else t0m[a] = v;
    endtask

    // One run: start, optional intruding start mid-run, latency and value checks
    task automatic run(input logic bwd, input logic [127:0] m, input logic [127:0] ka,
                       input logic [127:0] ks, input bit intrude, input string tag);
        logic [127:0] exp;
        bit early;
        exp = bwd ? bwd_model(m, ks) : fwd_model(m, ka);
        @(negedge clk);
        dir_bwd = bwd; data_in = m; key_add = ka; key_sub = ks; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            if (intrude && i == 3) begin
                start = 1'b1; dir_bwd = ~bwd; data_in = ~m;
            end else if (intrude && i == 4) begin
                start = 1'b0;
            end
            @(negedge clk);
            if (i < 8 && done) early = 1'b1;
        end
        check(!early && done, {"R8 done timing ", tag}, {127'd0, done}, 128'd1);
        check(data_out == exp, tag, data_out, exp);
        @(negedge clk);
        check(!done && data_out == exp, {"R8 pulse/hold ", tag}, data_out, exp);
    endtask

    initial begin
        logic [127:0] m, ka, ks;
        void'($urandom(32'h5a17c3e1));
        repeat (3) @(negedge clk);
        check(!done && data_out == '0, "R1 reset", data_out, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && data_out == '0, "R1 after reset", data_out, 128'd0);

        for (int a = 0; a < 256; a++) begin
            tbl_write(1'b0, 8'(a), $urandom);
            tbl_write(1'b1, 8'(a), $urandom);
        end

        // Directed corner cases
        run(1'b0, '0, '0, '0, 1'b0, "R2 R3 R4 forward zeros");
        run(1'b1, '0, '0, '0, 1'b0, "R5 R6 R7 backward zeros");
        run(1'b0, '1, {4{32'h0000_0001}}, '0, 1'b0, "R2 forward carry wrap");
        run(1'b1, '1, '0, {4{32'hffff_ffff}}, 1'b0, "R7 backward borrow wrap");

        // R10: rewrite entries used by the zero block and rerun
        tbl_write(1'b0, 8'h00, 32'hdead_beef);
        tbl_write(1'b1, 8'h00, 32'h1357_9bdf);
        run(1'b0, '0, '0, '0, 1'b0, "R10 rewritten table forward");
        run(1'b1, '0, '0, '0, 1'b0, "R10 rewritten table backward");

        // R9: intruding start during each direction
        m = {$urandom, $urandom, $urandom, $urandom};
        ka = {$urandom, $urandom, $urandom, $urandom};
        ks = {$urandom, $urandom, $urandom, $urandom};
        run(1'b0, m, ka, ks, 1'b1, "R9 forward start ignored");
        run(1'b1, m, ka, ks, 1'b1, "R9 backward start ignored");

        // Random blocks in both directions
        for (int n = 0; n < 20; n++) begin
            m  = {$urandom, $urandom, $urandom, $urandom};
            ka = {$urandom, $urandom, $urandom, $urandom};
            ks = {$urandom, $urandom, $urandom, $urandom};
            run(n[0], m, ka, ks, 1'b0, n[0] ? "R5 R6 R7 backward random"
                                            : "R2 R3 R4 forward random");
        end

        // R8: idle unit keeps its result
        m = data_out;
        repeat (5) @(negedge clk);
        check(data_out == m && !done, "R8 idle hold", data_out, m);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule